// File: doc/BRIEF.md
# Multiphase Serial Audio Transmitter

This block is the transmit half of a buffered synchronous audio port. Software or a DMA engine writes words into a single holding register. The block moves each word into a shift register as that word begins and drives it out MSB first on a serial data line. The timing comes from an external bit clock and frame sync. Both are treated as slow, already-synchronised levels that the system clock samples.

A control word sets up the frame. A frame has one phase or two, and each phase has its own word length and word count. The control word also selects a data delay of zero or one bit clock, whether mid-frame frame syncs are flagged, which bit-clock edge launches data, and whether the frame sync is active high or active low.

The transmitter enable works as a reset bit. While the enable is low, the transmitter is held in reset. Leaving reset takes effect only after the bit clock has toggled. If a word is due and the holding register is empty, the word sent in that same slot of the previous frame is sent again.

Top module: `mp_serial_tx`

## Requirements
- R1: Word-length codes map as 0=8, 1=12, 2=16, 3=20, 4=24, 5=32 bits, and codes 6 and 7 also give 32 bits. Write data is right-aligned, and each word is shifted out MSB first, one bit per launch edge.
- R2: Phase one carries (its count field + 1) words. When the dual-phase bit is set, phase two follows with its own count field + 1 words and its own word length.
- R3: The frame sync is sampled on launch edges. With delay 0, the first word's MSB is driven on the launch edge where the sync is seen active. With delay 1, that edge drives a low bit and the MSB follows on the next launch edge.
- R4: Clock-polarity bit = 1 makes the falling bit-clock edge the launch edge, and 0 makes the rising edge the launch edge. The serial output never changes except on a launch edge, or when the enable is low.
- R5: Frame-sync polarity bit = 1 makes the sync active low, and 0 makes it active high.
- R6: The serial output is low between frames, and it is low from the cycle after the enable goes low.
- R7: After the enable rises, a frame can start only once at least one bit-clock edge has been seen with the enable high. A sync present on that first edge does not start a frame.
- R8: A sync seen on a launch edge inside a frame, or during the delay bit, sets the sticky sync-error flag when the ignore bit is 0. When the ignore bit is 1, it has no effect. In both cases the frame continues unchanged.
- R9: Driving the enable low clears both the sync-error and underrun flags by the next cycle.
- R10: If the holding register is empty when a word starts, the word last sent in that slot is sent again, and the sticky underrun flag is set.
- R11: A sync on the launch edge that follows a frame's last bit starts the next frame at once, with no idle bit when the delay is 0.
- R12: A write that arrives after a word has been loaded is the word sent in the next slot. Frames fed in time never raise the underrun or sync-error flag.

Control word layout, with F = FL_W: wl1[2:0], wl2[5:3], count1[6+:F], count2[6+F+:F], dual[6+2F], delay[7+2F], ignore[8+2F], clock polarity[9+2F], sync polarity[10+2F].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low holds the transmitter in reset |
| ctrl | input | 11+2*FL_W | Frame control word |
| wr_data | input | 32 | Holding-register write data, right-aligned |
| wr_valid | input | 1 | Holding-register write strobe |
| bclk | input | 1 | Bit clock level |
| fsync | input | 1 | Frame sync level |
| sdo | output | 1 | Serial data output |
| underrun | output | 1 | Sticky underrun flag |
| sync_err | output | 1 | Sticky frame-sync error flag |

## Verification
The bench sweeps every word-length code against both data delays, both clock polarities, both sync polarities and single- and dual-phase frames. It checks every bit against a model word computed in the bench.

- A word-length off by one would misalign every later bit of the frame.
- A wrong phase counter would leave out or repeat a word at the phase boundary.
- A missing delay slot would shift the whole frame by one bit.

The bench also drives frames back to back, a sync on the very first edge after enable, mid-frame syncs with the ignore bit in both states, and underruns in both phases of a full-length frame. Any of these handled wrongly would show up as a sync taken too early, a dropped frame, a flag that did not stick, or silence in place of the replayed sample.

// File: rtl/mp_tx_pkg.sv
package mp_tx_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DLY   = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_t;

  function automatic logic [5:0] wl_bits(input logic [2:0] code);
    case (code)
      3'd0:    wl_bits = 6'd8;
      3'd1:    wl_bits = 6'd12;
      3'd2:    wl_bits = 6'd16;
      3'd3:    wl_bits = 6'd20;
      3'd4:    wl_bits = 6'd24;
      default: wl_bits = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/mp_tx_edge.sv
module mp_tx_edge (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic cpol,
  input  logic bclk,
  output logic launch,
  output logic armed
);
  logic bclk_q;

  always_ff @(posedge clk) begin
    bclk_q <= bclk;
    if (rst || !tx_en) armed <= 1'b0;
    else if (bclk ^ bclk_q) armed <= 1'b1;
  end

  assign launch = tx_en & (cpol ? (bclk_q & ~bclk) : (~bclk_q & bclk));
endmodule

// File: rtl/mp_tx_hold.sv
module mp_tx_hold #(
  parameter int FL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tx_en,
  input  logic [mp_tx_pkg::DATA_W-1:0] wr_data,
  input  logic                        wr_valid,
  input  logic                        load,
  input  logic [FL_W:0]               slot,
  output logic [mp_tx_pkg::DATA_W-1:0] word,
  output logic                        underrun
);
  localparam int SLOTS = 2 << FL_W;

  logic [mp_tx_pkg::DATA_W-1:0] replay [SLOTS];
  logic [mp_tx_pkg::DATA_W-1:0] hold;
  logic                         full;

  assign word = full ? hold : replay[slot];

  always_ff @(posedge clk) begin
    if (load) replay[slot] <= word;
  end

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      full     <= 1'b0;
      underrun <= 1'b0;
      hold     <= '0;
    end else begin
      if (wr_valid) hold <= wr_data;
      full <= wr_valid | (full & ~load);
      if (load && !full) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/mp_tx_seq.sv
module mp_tx_seq #(
  parameter int FL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tx_en,
  input  logic                        launch,
  input  logic                        armed,
  input  logic                        fs_act,
  input  logic [2:0]                  wl1,
  input  logic [2:0]                  wl2,
  input  logic [FL_W-1:0]             fl1,
  input  logic [FL_W-1:0]             fl2,
  input  logic                        dual,
  input  logic                        dly,
  input  logic                        ign,
  input  logic [mp_tx_pkg::DATA_W-1:0] word,
  output logic                        load,
  output logic [FL_W:0]               slot,
  output logic                        sdo,
  output logic                        sync_err
);
  import mp_tx_pkg::*;

  tx_state_t         state;
  logic              phase;
  logic [FL_W-1:0]   wcnt;
  logic [4:0]        bidx;
  logic [DATA_W-1:0] sreg;

  logic [FL_W-1:0] cur_fl;
  logic            last_word, word_end, frame_end, can_start;
  logic            first_now, next_word, mid_fs;
  logic            nx_phase;
  logic [FL_W-1:0] nx_wcnt;
  logic [5:0]      nx_len;
  logic [4:0]      nx_msb;

  always_comb begin
    cur_fl    = phase ? fl2 : fl1;
    last_word = (wcnt == cur_fl) && (phase || !dual);
    word_end  = (state == ST_SHIFT) && (bidx == 5'd0);
    frame_end = word_end && last_word;
    can_start = launch && armed && fs_act && ((state == ST_IDLE) || frame_end);
    first_now = (can_start && !dly) || (launch && state == ST_DLY);
    next_word = launch && word_end && !last_word;
    load      = first_now || next_word;
    mid_fs    = launch && fs_act &&
                ((state == ST_DLY) || (state == ST_SHIFT && !frame_end));
    if (first_now) begin
      nx_phase = 1'b0;
      nx_wcnt  = '0;
    end else if (wcnt == cur_fl) begin
      nx_phase = 1'b1;
      nx_wcnt  = '0;
    end else begin
      nx_phase = phase;
      nx_wcnt  = wcnt + 1'b1;
    end
    slot   = {nx_phase, nx_wcnt};
    nx_len = wl_bits(nx_phase ? wl2 : wl1);
    nx_msb = 5'(nx_len - 6'd1);
  end

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      wcnt     <= '0;
      bidx     <= '0;
      sreg     <= '0;
      sdo      <= 1'b0;
      sync_err <= 1'b0;
    end else if (launch) begin
      if (load) begin
        sreg  <= word;
        bidx  <= nx_msb;
        phase <= nx_phase;
        wcnt  <= nx_wcnt;
        sdo   <= word[nx_msb];
        state <= ST_SHIFT;
      end else if (can_start) begin
        state <= ST_DLY;
        sdo   <= 1'b0;
      end else if (state == ST_SHIFT && bidx != 5'd0) begin
        bidx <= bidx - 5'd1;
        sdo  <= sreg[bidx - 5'd1];
      end else if (frame_end) begin
        state <= ST_IDLE;
        sdo   <= 1'b0;
      end
      if (mid_fs && !ign) sync_err <= 1'b1;
    end
  end
endmodule

// File: rtl/mp_serial_tx.sv
module mp_serial_tx #(
  parameter int FL_W   = 3,
  parameter int CTRL_W = 11 + 2 * FL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [31:0]       wr_data,
  input  logic              wr_valid,
  input  logic              bclk,
  input  logic              fsync,
  output logic              sdo,
  output logic              underrun,
  output logic              sync_err
);
  localparam int B_FL1  = 6;
  localparam int B_FL2  = 6 + FL_W;
  localparam int B_DUAL = 6 + 2 * FL_W;

  logic launch, armed, load;
  logic [FL_W:0] slot;
  logic [31:0]   word;
  logic          fs_act;

  assign fs_act = fsync ^ ctrl[B_DUAL + 4];

  mp_tx_edge u_edge (
    .clk(clk), .rst(rst), .tx_en(tx_en), .cpol(ctrl[B_DUAL + 3]),
    .bclk(bclk), .launch(launch), .armed(armed)
  );

  mp_tx_hold #(.FL_W(FL_W)) u_hold (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wr_data(wr_data),
    .wr_valid(wr_valid), .load(load), .slot(slot), .word(word),
    .underrun(underrun)
  );

  mp_tx_seq #(.FL_W(FL_W)) u_seq (
    .clk(clk), .rst(rst), .tx_en(tx_en), .launch(launch), .armed(armed),
    .fs_act(fs_act), .wl1(ctrl[2:0]), .wl2(ctrl[5:3]),
    .fl1(ctrl[B_FL1 +: FL_W]), .fl2(ctrl[B_FL2 +: FL_W]),
    .dual(ctrl[B_DUAL]), .dly(ctrl[B_DUAL + 1]), .ign(ctrl[B_DUAL + 2]),
    .word(word), .load(load), .slot(slot), .sdo(sdo), .sync_err(sync_err)
  );
endmodule

// File: rtl/mp_serial_tx_chk.sv
module mp_serial_tx_chk #(
  parameter int FL_W   = 3,
  parameter int CTRL_W = 11 + 2 * FL_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic [CTRL_W-1:0] ctrl,
  input logic              bclk,
  input logic              sdo,
  input logic              underrun,
  input logic              sync_err
);
  logic bclk_prev;
  logic launch_c;

  always_ff @(posedge clk) bclk_prev <= bclk;

  assign launch_c = ctrl[9 + 2 * FL_W] ? (bclk_prev & ~bclk) : (~bclk_prev & bclk);

  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !sdo);

  assert_hold_between_edges_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !launch_c) |=> $stable(sdo));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (sync_err && tx_en) |=> sync_err);

  assert_err_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
    !launch_c |=> !$rose(sync_err));

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!sync_err && !underrun));

  assert_urun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (underrun && tx_en) |=> underrun);
endmodule

bind mp_serial_tx mp_serial_tx_chk #(.FL_W(FL_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .ctrl(ctrl), .bclk(bclk),
  .sdo(sdo), .underrun(underrun), .sync_err(sync_err)
);

// File: tb/mp_serial_tx_test.sv
module mp_serial_tx_test;
  localparam int FL_W   = 3;
  localparam int CTRL_W = 11 + 2 * FL_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0;
  logic [CTRL_W-1:0] ctrl = '0;
  logic [31:0] wr_data = '0;
  logic wr_valid = 1'b0;
  logic bclk = 1'b0;
  logic fsync = 1'b0;
  logic sdo, underrun, sync_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [2:0] wl1c, wl2c;
  logic [FL_W-1:0] fl1, fl2;
  logic dual, dly, ign, cpol, fpol;
  logic [31:0] prevw [16];

  always #4 clk = ~clk;

  mp_serial_tx #(.FL_W(FL_W)) uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .ctrl(ctrl), .wr_data(wr_data),
    .wr_valid(wr_valid), .bclk(bclk), .fsync(fsync), .sdo(sdo),
    .underrun(underrun), .sync_err(sync_err)
  );

  function automatic int bits_of(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_step(input logic fs_on, output logic got);
    fsync = fs_on ^ fpol;
    bclk  = cpol ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
    bclk  = cpol ? 1'b1 : 1'b0;
    repeat (2) @(negedge clk);
    got = sdo;
  endtask

  task automatic write_word(input logic [31:0] w);
    wr_data  = w;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic setup(input bit do_arm);
    logic g;
    tx_en = 1'b0;
    @(negedge clk);
    ctrl  = {fpol, cpol, ign, dly, dual, fl2, fl1, wl2c, wl1c};
    bclk  = cpol ? 1'b1 : 1'b0;
    fsync = fpol;
    repeat (2) @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
    if (do_arm) bit_step(1'b0, g);
  endtask

  task automatic run_frame(input string req, input int seed, input int skip,
                           input int fs_mid, input bit tail);
    int n, n1, len, slot, bitno;
    logic [31:0] words [16];
    logic [31:0] expw  [16];
    int lens [16];
    int slots [16];
    logic g, fsb;
    n1 = int'(fl1) + 1;
    n  = n1 + (dual ? int'(fl2) + 1 : 0);
    for (int k = 0; k < n; k++) begin
      lens[k]  = (k < n1) ? bits_of(wl1c) : bits_of(wl2c);
      slots[k] = (k < n1) ? k : 8 + (k - n1);
      words[k] = 32'((longint'(seed) * 64'h9E3779B1 + longint'(k) * 64'h85EBCA6B) ^ (seed << 7));
      if (lens[k] < 32) words[k] = words[k] & ((32'd1 << lens[k]) - 32'd1);
      expw[k] = (k == skip) ? prevw[slots[k]] : words[k];
    end
    if (skip != 0) write_word(words[0]);
    if (dly) begin
      bit_step(1'b1, g);
      check({req, " R3 delay bit"}, 32'(g), 32'd0);
    end
    bitno = 0;
    for (int k = 0; k < n; k++) begin
      len = lens[k];
      for (int b = len - 1; b >= 0; b--) begin
        fsb = ((!dly && k == 0 && b == len - 1) || bitno == fs_mid) ? 1'b1 : 1'b0;
        bit_step(fsb, g);
        check(req, 32'(g), 32'(expw[k][b]));
        if (b == len - 1 && k + 1 < n && k + 1 != skip) write_word(words[k + 1]);
        bitno++;
      end
    end
    for (int k = 0; k < n; k++) begin
      slot = slots[k];
      prevw[slot] = expw[k];
    end
    if (tail) begin
      bit_step(1'b0, g);
      check("R6 idle low after frame", 32'(g), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic g;
    wl1c = 3'd2; wl2c = 3'd2; fl1 = '0; fl2 = '0;
    dual = 1'b0; dly = 1'b0; ign = 1'b1; cpol = 1'b1; fpol = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 reset sdo", 32'(sdo), 32'd0);
    check("R9 reset underrun", 32'(underrun), 32'd0);
    check("R9 reset sync_err", 32'(sync_err), 32'd0);

    // R6: disabled transmitter ignores clock and sync
    for (int i = 0; i < 4; i++) begin
      bit_step(1'b1, g);
      check("R6 disabled output", 32'(g), 32'd0);
    end

    // R7: sync on the first edge after enable is not taken
    setup(1'b0);
    bit_step(1'b1, g);
    check("R7 unarmed first edge", 32'(g), 32'd0);
    bit_step(1'b0, g);
    check("R7 no frame started", 32'(g), 32'd0);
    run_frame("R7 frame after arming", 3, -1, -1, 1'b1);

    // R1 R2 R4 R5 sweep
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 4; m++) begin
        wl1c = 3'(c); wl2c = 3'((c + 5) % 8);
        fl1 = FL_W'((c + m) % 3); fl2 = FL_W'(m % 2);
        dual = 1'((c + m) % 2); dly = 1'(m & 1); cpol = 1'(m >> 1);
        fpol = 1'(m ^ (m >> 1) ^ c); ign = 1'b1;
        setup(1'b1);
        run_frame("R1 R2 R4 R5 sweep", c * 4 + m + 10, -1, -1, 1'b1);
        run_frame("R1 R2 R4 R5 sweep", c * 4 + m + 50, -1, -1, 1'b1);
        check("R12 no underrun", 32'(underrun), 32'd0);
        check("R12 no sync error", 32'(sync_err), 32'd0);
      end
    end

    // R10: underrun replay in both phases of a full-length frame
    wl1c = 3'd0; wl2c = 3'd1; fl1 = 3'd7; fl2 = 3'd7; dual = 1'b1;
    dly = 1'b0; cpol = 1'b0; fpol = 1'b1; ign = 1'b1;
    setup(1'b1);
    run_frame("R2 full length", 100, -1, -1, 1'b1);
    check("R10 no underrun yet", 32'(underrun), 32'd0);
    run_frame("R10 replay phase one", 101, 5, -1, 1'b1);
    check("R10 underrun flag", 32'(underrun), 32'd1);
    run_frame("R10 replay phase two", 102, 12, -1, 1'b1);
    check("R10 underrun sticky", 32'(underrun), 32'd1);
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 underrun cleared", 32'(underrun), 32'd0);

    // R8: mid-frame sync, flagged and ignored
    wl1c = 3'd2; wl2c = 3'd0; fl1 = 3'd1; fl2 = 3'd0; dual = 1'b1;
    dly = 1'b1; cpol = 1'b1; fpol = 1'b0; ign = 1'b0;
    setup(1'b1);
    run_frame("R8 frame continues", 200, -1, 7, 1'b1);
    check("R8 sync error set", 32'(sync_err), 32'd1);
    run_frame("R8 clean frame", 201, -1, -1, 1'b1);
    check("R8 sync error sticky", 32'(sync_err), 32'd1);
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 sync error cleared", 32'(sync_err), 32'd0);
    ign = 1'b1;
    setup(1'b1);
    run_frame("R8 ignored sync", 202, -1, 20, 1'b1);
    check("R8 ignore keeps flag low", 32'(sync_err), 32'd0);

    // R11: back-to-back frames, both delays
    for (int d = 0; d < 2; d++) begin
      wl1c = 3'd0; fl1 = 3'd1; dual = 1'b0; dly = 1'(d); cpol = 1'b0;
      fpol = 1'b0; ign = 1'b0;
      setup(1'b1);
      run_frame("R11 first", 300 + d, -1, -1, 1'b0);
      run_frame("R11 chained", 310 + d, -1, -1, 1'b0);
      run_frame("R11 chained", 320 + d, -1, -1, 1'b1);
      check("R11 no sync error", 32'(sync_err), 32'd0);
    end

    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 low when disabled", 32'(sdo), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule